// File: doc/BRIEF.md
# Branch Condition and Target Evaluator

This block decides, for one short relative branch per cycle, whether the branch is taken and which instruction pointer comes next. It covers the eighteen flag-combination branch tests and the four iteration-control forms that work on a 16-bit count register. A 5-bit selector chooses the test. The flags come in as five separate bits: carry, zero, sign, overflow and parity. When the branch is taken, the next pointer is the address of the following instruction plus a sign-extended 8-bit displacement. When it is not taken, the next pointer is the address of the following instruction itself.

All results are registered and appear one clock after the request. The loop forms also return the decremented count and raise a write strobe, so the surrounding core can update its count register. Adding the displacement wraps within the 16-bit pointer, so no segment base ever changes.

Top module: `branch_eval`

## Requirements
- R1: While `rst` is high at a clock edge, the next state of `out_valid`, `taken`, `ip_out`, `count_out` and `count_we` is zero.
- R2: `out_valid` is `in_valid` delayed by one clock, and `count_we` is high only in the cycle after an accepted loop-form request. A cycle with `in_valid` low leaves `taken`, `ip_out` and `count_out` unchanged.
- R3: Selectors 0 to 15 pair a base test with its negation, and an odd code inverts the base. The base tests for code pairs 0/1 through 14/15 are, in order: OF, CF, ZF, CF|ZF, SF, PF, SF^OF, and ZF|(SF^OF).
- R4: Selector 16 branches on CF=1 and selector 17 branches on CF=0.
- R5: A taken branch gives `ip_out` = `ip_next` + sign-extended `disp`, modulo 2^16. A branch that is not taken gives `ip_out` = `ip_next`.
- R6: A displacement of zero yields `ip_out` = `ip_next` even when the branch is taken.
- R7: Selector 18 (loop) sets `count_out` to `count_in`−1 and raises `count_we`. It is taken when the new count is nonzero.
- R8: Selector 19 works as selector 18 but also needs ZF=1 to be taken. Selector 20 also needs ZF=0.
- R9: Selector 21 is taken when `count_in` is zero. It returns `count_out` = `count_in` and leaves `count_we` low.
- R10: Selectors 22 to 31 are never taken. They return `count_out` = `count_in` and leave `count_we` low.
- R11: The loop forms wrap a count of zero to 0xFFFF, and that new count is nonzero, so the branch is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| cond_sel | input | 5 | Branch test selector |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_o | input | 1 | Overflow flag |
| flag_p | input | 1 | Parity flag |
| count_in | input | 16 | Current count register |
| disp | input | 8 | Signed branch displacement |
| ip_next | input | 16 | Address of the following instruction |
| out_valid | output | 1 | Result strobe |
| taken | output | 1 | Branch taken |
| ip_out | output | 16 | Next instruction pointer |
| count_out | output | 16 | Updated count value |
| count_we | output | 1 | Count write strobe |

## Verification
Every selector code is swept against all 32 flag combinations. This shows that each test reads the right flags and that each odd code inverts its partner. The sweep also cycles the counts through 0 to 3, which separates the decrement-to-zero case from the wrap-to-0xFFFF case. The displacements 0x00, 0x7F, 0x80 and 0xFF are mixed with pointers near both ends of the address space, which shows that sign extension and modulo wrap are both done correctly. Directed vectors then check reset, idle hold and the unused selector codes.

// File: rtl/branch_eval_pkg.sv
package branch_eval_pkg;
  localparam int SEL_W = 5;

  typedef enum logic [SEL_W-1:0] {
    SEL_OVF    = 5'd0,
    SEL_NOVF   = 5'd1,
    SEL_CY     = 5'd2,
    SEL_NCY    = 5'd3,
    SEL_ZR     = 5'd4,
    SEL_NZR    = 5'd5,
    SEL_BE     = 5'd6,
    SEL_ABV    = 5'd7,
    SEL_SGN    = 5'd8,
    SEL_NSGN   = 5'd9,
    SEL_PAR    = 5'd10,
    SEL_NPAR   = 5'd11,
    SEL_LT     = 5'd12,
    SEL_GE     = 5'd13,
    SEL_LE     = 5'd14,
    SEL_GT     = 5'd15,
    SEL_CYA    = 5'd16,
    SEL_NCYA   = 5'd17,
    SEL_LOOP   = 5'd18,
    SEL_LOOPZ  = 5'd19,
    SEL_LOOPNZ = 5'd20,
    SEL_CNTZ   = 5'd21
  } sel_e;

  localparam int FLAG_TESTS = 18;
endpackage

// File: rtl/br_flag_test.sv
module br_flag_test
  import branch_eval_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             cf,
  input  logic             zf,
  input  logic             sf,
  input  logic             of,
  input  logic             pf,
  output logic             hit
);
  localparam int PAIRS = 1 << (SEL_W - 1);

  logic [PAIRS-1:0] base;
  logic             lt;

  always_comb begin
    lt      = sf ^ of;
    base    = '0;
    base[0] = of;
    base[1] = cf;
    base[2] = zf;
    base[3] = cf | zf;
    base[4] = sf;
    base[5] = pf;
    base[6] = lt;
    base[7] = zf | lt;
    base[8] = cf;
  end

  always_comb begin
    if (int'(sel) < FLAG_TESTS) hit = base[sel[SEL_W-1:1]] ^ sel[0];
    else                        hit = 1'b0;
  end
endmodule

// File: rtl/br_iter_ctrl.sv
module br_iter_ctrl
  import branch_eval_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             zf,
  input  logic [CNT_W-1:0] cnt,
  output logic             hit,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             cnt_wr
);
  logic [CNT_W-1:0] dec;
  logic             dec_nz;

  assign dec    = cnt - CNT_W'(1);
  assign dec_nz = |dec;

  always_comb begin
    hit     = 1'b0;
    cnt_nxt = cnt;
    cnt_wr  = 1'b0;
    case (sel)
      SEL_LOOP: begin
        hit = dec_nz; cnt_nxt = dec; cnt_wr = 1'b1;
      end
      SEL_LOOPZ: begin
        hit = dec_nz & zf; cnt_nxt = dec; cnt_wr = 1'b1;
      end
      SEL_LOOPNZ: begin
        hit = dec_nz & ~zf; cnt_nxt = dec; cnt_wr = 1'b1;
      end
      SEL_CNTZ: hit = ~|cnt;
      default: ;
    endcase
  end
endmodule

// File: rtl/br_target.sv
module br_target #(
  parameter int IP_W   = 16,
  parameter int DISP_W = 8
) (
  input  logic [IP_W-1:0]   base_ip,
  input  logic [DISP_W-1:0] disp,
  output logic [IP_W-1:0]   target
);
  logic [IP_W-1:0] disp_ext;

  generate
    if (IP_W > DISP_W) begin : g_sext
      assign disp_ext = {{(IP_W-DISP_W){disp[DISP_W-1]}}, disp};
    end else begin : g_trunc
      assign disp_ext = disp[IP_W-1:0];
    end
  endgenerate

  assign target = base_ip + disp_ext;
endmodule

// File: rtl/branch_eval.sv
module branch_eval
  import branch_eval_pkg::*;
#(
  parameter int IP_W   = 16,
  parameter int DISP_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [SEL_W-1:0]  cond_sel,
  input  logic              flag_c,
  input  logic              flag_z,
  input  logic              flag_s,
  input  logic              flag_o,
  input  logic              flag_p,
  input  logic [CNT_W-1:0]  count_in,
  input  logic [DISP_W-1:0] disp,
  input  logic [IP_W-1:0]   ip_next,
  output logic              out_valid,
  output logic              taken,
  output logic [IP_W-1:0]   ip_out,
  output logic [CNT_W-1:0]  count_out,
  output logic              count_we
);
  logic             flag_hit;
  logic             iter_hit;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_wr;
  logic [IP_W-1:0]  target;
  logic             take_c;
  logic [IP_W-1:0]  ip_c;

  br_flag_test u_flag (
    .sel (cond_sel),
    .cf  (flag_c),
    .zf  (flag_z),
    .sf  (flag_s),
    .of  (flag_o),
    .pf  (flag_p),
    .hit (flag_hit)
  );

  br_iter_ctrl #(.CNT_W(CNT_W)) u_iter (
    .sel     (cond_sel),
    .zf      (flag_z),
    .cnt     (count_in),
    .hit     (iter_hit),
    .cnt_nxt (cnt_nxt),
    .cnt_wr  (cnt_wr)
  );

  br_target #(.IP_W(IP_W), .DISP_W(DISP_W)) u_tgt (
    .base_ip (ip_next),
    .disp    (disp),
    .target  (target)
  );

  assign take_c = flag_hit | iter_hit;
  assign ip_c   = take_c ? target : ip_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      ip_out    <= '0;
      count_out <= '0;
      count_we  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      count_we  <= in_valid & cnt_wr;
      if (in_valid) begin
        taken     <= take_c;
        ip_out    <= ip_c;
        count_out <= cnt_nxt;
      end
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && !taken && !count_we && ip_out == '0)); // R1

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(ip_out) && $stable(count_out) && !count_we)); // R2

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !take_c) |=> (ip_out == $past(ip_next))); // R5

  AST_LOOP_DEC: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond_sel == SEL_LOOP) |=>
      (count_we && count_out == $past(count_in) - CNT_W'(1))); // R7

  AST_CNTZ_KEEP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond_sel == SEL_CNTZ) |=>
      (!count_we && count_out == $past(count_in))); // R9

  AST_UNUSED_SEL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && int'(cond_sel) > int'(SEL_CNTZ)) |=> (!taken && !count_we)); // R10
endmodule

// File: tb/branch_eval_tb.sv
`timescale 1ns/1ps
module branch_eval_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [4:0]  cond_sel;
  logic        flag_c, flag_z, flag_s, flag_o, flag_p;
  logic [15:0] count_in;
  logic [7:0]  disp;
  logic [15:0] ip_next;
  logic        out_valid, taken, count_we;
  logic [15:0] ip_out, count_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  branch_eval u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cond_sel(cond_sel),
    .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o),
    .flag_p(flag_p), .count_in(count_in), .disp(disp), .ip_next(ip_next),
    .out_valid(out_valid), .taken(taken), .ip_out(ip_out),
    .count_out(count_out), .count_we(count_we)
  );

  // {sel, flags{c,z,s,o,p}, count, disp, ip_next, exp_taken, exp_ip, exp_count}
  localparam int NV = 14;
  localparam logic [82:0] VEC [NV] = '{
    {5'd0,  5'b00010, 16'd5,     8'h10, 16'h1000, 1'b1, 16'h1010, 16'd5},
    {5'd1,  5'b00010, 16'd5,     8'h10, 16'h1000, 1'b0, 16'h1000, 16'd5},
    {5'd2,  5'b10000, 16'd5,     8'h80, 16'h1000, 1'b1, 16'h0F80, 16'd5},
    {5'd6,  5'b01000, 16'd5,     8'h7F, 16'hFFF0, 1'b1, 16'h006F, 16'd5},
    {5'd15, 5'b00110, 16'd5,     8'hFF, 16'h0000, 1'b1, 16'hFFFF, 16'd5},
    {5'd12, 5'b00110, 16'd5,     8'h10, 16'h2000, 1'b0, 16'h2000, 16'd5},
    {5'd18, 5'b00000, 16'd1,     8'h20, 16'h3000, 1'b0, 16'h3000, 16'd0},
    {5'd18, 5'b00000, 16'd0,     8'h20, 16'h3000, 1'b1, 16'h3020, 16'hFFFF},
    {5'd19, 5'b00000, 16'd3,     8'h20, 16'h3000, 1'b0, 16'h3000, 16'd2},
    {5'd20, 5'b00000, 16'd3,     8'h20, 16'h3000, 1'b1, 16'h3020, 16'd2},
    {5'd21, 5'b00000, 16'd0,     8'hF0, 16'h0008, 1'b1, 16'hFFF8, 16'd0},
    {5'd21, 5'b00000, 16'd7,     8'hF0, 16'h0008, 1'b0, 16'h0008, 16'd7},
    {5'd16, 5'b10000, 16'd9,     8'h00, 16'h1234, 1'b1, 16'h1234, 16'd9},
    {5'd25, 5'b11111, 16'd9,     8'h40, 16'h4000, 1'b0, 16'h4000, 16'd9}
  };

  function automatic string req_of(input logic [4:0] s);
    if (s < 5'd16)       return "R3";
    else if (s < 5'd18)  return "R4";
    else if (s == 5'd18) return "R7";
    else if (s < 5'd21)  return "R8";
    else if (s == 5'd21) return "R9";
    else                 return "R10";
  endfunction

  // returns {we, taken, ip, count}
  function automatic logic [33:0] ref_eval(input logic [4:0] s, input logic [4:0] f,
                                           input logic [15:0] c, input logic [7:0] d,
                                           input logic [15:0] n);
    logic cf, zf, sf, of, pf, t, we;
    logic [15:0] nc;
    {cf, zf, sf, of, pf} = f;
    t = 1'b0; we = 1'b0; nc = c;
    case (s)
      5'd0:  t = of;
      5'd1:  t = !of;
      5'd2:  t = cf;
      5'd3:  t = !cf;
      5'd4:  t = zf;
      5'd5:  t = !zf;
      5'd6:  t = cf || zf;
      5'd7:  t = !cf && !zf;
      5'd8:  t = sf;
      5'd9:  t = !sf;
      5'd10: t = pf;
      5'd11: t = !pf;
      5'd12: t = (sf != of);
      5'd13: t = (sf == of);
      5'd14: t = zf || (sf != of);
      5'd15: t = !zf && (sf == of);
      5'd16: t = cf;
      5'd17: t = !cf;
      5'd18, 5'd19, 5'd20: begin
        nc = c + 16'hFFFF; we = 1'b1;
        t = (nc != 16'd0) && (s == 5'd18 || (s == 5'd19 && zf) || (s == 5'd20 && !zf));
      end
      5'd21: t = (c == 16'd0);
      default: t = 1'b0;
    endcase
    return {we, t, (t ? n + {{8{d[7]}}, d} : n), nc};
  endfunction

  task automatic drive(input logic [4:0] s, input logic [4:0] f, input logic [15:0] c,
                       input logic [7:0] d, input logic [15:0] n);
    @(negedge clk);
    in_valid = 1'b1; cond_sel = s;
    {flag_c, flag_z, flag_s, flag_o, flag_p} = f;
    count_in = c; disp = d; ip_next = n;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check(input string req, input logic et, input logic [15:0] eip,
                       input logic [15:0] ecnt, input logic ewe);
    checks++;
    if (out_valid !== 1'b1 || taken !== et || ip_out !== eip ||
        count_out !== ecnt || count_we !== ewe) begin
      errors++;
      $display("FAIL %s: got v=%b t=%b ip=%h cnt=%h we=%b, exp v=1 t=%b ip=%h cnt=%h we=%b",
               req, out_valid, taken, ip_out, count_out, count_we, et, eip, ecnt, ewe);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [33:0] r;
    logic [15:0] held_ip, held_cnt;
    rst = 1'b1; in_valid = 1'b0; cond_sel = '0;
    {flag_c, flag_z, flag_s, flag_o, flag_p} = '0;
    count_in = '0; disp = '0; ip_next = '0;
    repeat (3) @(negedge clk);

    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || taken !== 1'b0 || ip_out !== 16'h0 ||
        count_out !== 16'h0 || count_we !== 1'b0) begin
      errors++;
      $display("FAIL R1: got v=%b t=%b ip=%h cnt=%h we=%b, exp all zero",
               out_valid, taken, ip_out, count_out, count_we);
    end
    rst = 1'b0;

    // table walk (R3 R4 R5 R6 R7 R8 R9 R10 R11)
    for (int i = 0; i < NV; i++) begin
      logic [82:0] v;
      v = VEC[i];
      drive(v[82:78], v[77:73], v[72:57], v[56:49], v[48:33]);
      check(req_of(v[82:78]), v[32], v[31:16], v[15:0],
            (v[82:78] >= 5'd18 && v[82:78] <= 5'd20));
    end

    // full sweep of selectors x flags with reference function
    for (int s = 0; s < 32; s++) begin
      for (int f = 0; f < 32; f++) begin
        logic [15:0] c, n;
        logic [7:0] d;
        c = 16'(f % 4);
        case (f % 4)
          0: d = 8'h00;
          1: d = 8'h7F;
          2: d = 8'h80;
          default: d = 8'hFF;
        endcase
        n = 16'hFFC0 + 16'(f * 16'h0811);
        r = ref_eval(5'(s), 5'(f), c, d, n);
        drive(5'(s), 5'(f), c, d, n);
        check(req_of(5'(s)), r[32], r[31:16], r[15:0], r[33]);
      end
    end

    // R5: forward wrap past 0xFFFF
    drive(5'd4, 5'b01000, 16'd1, 8'h20, 16'hFFF0);
    check("R5", 1'b1, 16'h0010, 16'd1, 1'b0);
    // R6: zero displacement taken
    drive(5'd12, 5'b00100, 16'd1, 8'h00, 16'h5555);
    check("R6", 1'b1, 16'h5555, 16'd1, 1'b0);
    // R11: loop-not-zero from count zero wraps and is taken
    drive(5'd20, 5'b00000, 16'd0, 8'hFE, 16'h0100);
    check("R11", 1'b1, 16'h00FE, 16'hFFFF, 1'b1);

    // R2: idle cycle holds data, drops valid and write strobe
    held_ip = ip_out; held_cnt = count_out;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || count_we !== 1'b0 || ip_out !== held_ip ||
        count_out !== held_cnt || taken !== 1'b1) begin
      errors++;
      $display("FAIL R2: got v=%b we=%b ip=%h cnt=%h t=%b, exp v=0 we=0 ip=%h cnt=%h t=1",
               out_valid, count_we, ip_out, count_out, taken, held_ip, held_cnt);
    end

    // R1: reset after activity clears outputs
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (out_valid !== 1'b0 || taken !== 1'b0 || ip_out !== 16'h0 || count_out !== 16'h0) begin
      errors++;
      $display("FAIL R1: got v=%b t=%b ip=%h cnt=%h, exp all zero",
               out_valid, taken, ip_out, count_out);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule